// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

This block collects up to 32 interrupt lines and presents them to a processor as one request line and a small word-addressed register window. Each line is captured into a status word. A build-time mask picks the capture style for each line: rising edge, or plain level. The status word is filtered by an enable word to give pending bits. A two-bit master control gates the request: one bit is a global on/off, and the other is a hardware-request permit that cannot be cleared once it is set.

Software uses the window to steer the controller. It can replace the enable word outright, or it can set or clear chosen enable bits with single writes, so no read-modify-write is needed. A write-one-to-clear acknowledge port clears status bits. A vector port reports the number of the lowest pending line. Reads are combinational from the registers. Writes take effect at the next rising clock edge.

Top module: `mmio_irq_ctrl`

## Requirements
- R1: After reset, the status, pending, enable and master words all read zero, the vector word reads 0xFFFFFFFF and irq_out is low.
- R2: Line i is level-sensitive when EDGE_MASK bit i is 0. Its status bit is set on every clock edge where the line is high. Line i is edge-sensitive when EDGE_MASK bit i is 1. Its status bit is set on an edge where the line is high and was low at the previous edge; the remembered previous value is 0 after reset. A set status bit stays set until it is acknowledged.
- R3: A write to word offset 2 (byte 0x08) replaces the enable word. A write to offset 4 (0x10) ORs the data into the enable word. A write to offset 5 (0x14) clears the enable bits that are 1 in the data.
- R4: A write to offset 3 (0x0C) clears every status bit whose data bit is 1. If a new capture arrives in the same cycle for that bit, the capture wins and the bit stays set. A level line that is still high is therefore set again at once.
- R5: Offset 1 (0x04) reads the pending word, which is status AND enable.
- R6: irq_out is high exactly when master bit 0 and master bit 1 are both 1 and at least one pending bit is 1.
- R7: Offset 7 (0x1C) holds the global enable in bit 0, which writes can set and clear. It holds the hardware-request permit in bit 1: a write of 1 sets it, and only reset clears it. All other bits read 0.
- R8: Offset 6 (0x18) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R9: Status, pending and enable bits at positions NUM_SRC and above always read zero.
- R10: Writes to offsets 0, 1 and 6 have no effect. Offsets 3, 4 and 5 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | NUM_SRC | Interrupt lines |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the word |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that irq_src and the bus inputs are steady around each rising edge and that a write strobe lasts one cycle for each access. They also assume that only bits 4:2 of the address take part in decoding. The bench drives every input just after a falling edge and holds it through the next rising edge. Its random phase mixes all eight offsets, all-ones data and toggling lines, so same-cycle acknowledge and capture collisions happen often.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [2:0] OFF_STATUS = 3'd0;
  localparam logic [2:0] OFF_PEND   = 3'd1;
  localparam logic [2:0] OFF_ENABLE = 3'd2;
  localparam logic [2:0] OFF_ACK    = 3'd3;
  localparam logic [2:0] OFF_SETEN  = 3'd4;
  localparam logic [2:0] OFF_CLREN  = 3'd5;
  localparam logic [2:0] OFF_VECTOR = 3'd6;
  localparam logic [2:0] OFF_MASTER = 3'd7;

  localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

  // Mask of the implemented line positions.
  function automatic logic [31:0] line_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  // Index of the lowest set bit, or NO_VECTOR when the word is empty.
  function automatic logic [31:0] lowest_index(input logic [31:0] v);
    logic [31:0] idx;
    idx = NO_VECTOR;
    for (int i = 31; i >= 0; i--) if (v[i]) idx = 32'(i);
    return idx;
  endfunction

  // Next value of the enable word for one bus write.
  function automatic logic [31:0] enable_update(input logic [31:0] cur,
                                                input logic [2:0]  off,
                                                input logic [31:0] data);
    case (off)
      OFF_ENABLE: return data;
      OFF_SETEN:  return cur | data;
      OFF_CLREN:  return cur & ~data;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense #(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lines,
  output logic [31:0]        hit
);
  for (genvar i = 0; i < 32; i++) begin : g_line
    if (i >= NUM_SRC) begin : g_absent
      assign hit[i] = 1'b0;
    end else if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lines[i];
      end
      assign hit[i] = lines[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = lines[i];
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [31:0] pend,
  output logic [31:0] vec
);
  assign vec = lowest_index(pend);
endmodule

// File: rtl/mmio_irq_ctrl.sv
module mmio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0,
  parameter int          ADDR_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam logic [31:0] LMASK = line_mask(NUM_SRC);

  logic [31:0] status_r, enable_r, pending_w, vec_w, hit, ack_mask;
  logic        master_en, hw_en;
  logic        ack_wr, set_wr, clr_wr, ena_wr, mst_wr;
  logic [2:0]  wr_off;

  assign wr_off   = bus_addr[4:2];
  assign ack_wr   = bus_we && (wr_off == OFF_ACK);
  assign set_wr   = bus_we && (wr_off == OFF_SETEN);
  assign clr_wr   = bus_we && (wr_off == OFF_CLREN);
  assign ena_wr   = bus_we && (wr_off == OFF_ENABLE);
  assign mst_wr   = bus_we && (wr_off == OFF_MASTER);
  assign ack_mask = ack_wr ? bus_wdata : '0;

  irqc_sense #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_sense (
    .clk(clk), .rst_n(rst_n), .lines(irq_src), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_r  <= '0;
      enable_r  <= '0;
      master_en <= 1'b0;
      hw_en     <= 1'b0;
    end else begin
      status_r <= ((status_r & ~ack_mask) | hit) & LMASK;
      if (ena_wr || set_wr || clr_wr)
        enable_r <= enable_update(enable_r, wr_off, bus_wdata) & LMASK;
      if (mst_wr) begin
        master_en <= bus_wdata[0];
        hw_en     <= hw_en | bus_wdata[1];
      end
    end
  end

  assign pending_w = status_r & enable_r;

  irqc_prio u_prio (.pend(pending_w), .vec(vec_w));

  assign irq_out = master_en && hw_en && (pending_w != '0);

  always_comb begin
    case (bus_addr[4:2])
      OFF_STATUS: bus_rdata = status_r;
      OFF_PEND:   bus_rdata = pending_w;
      OFF_ENABLE: bus_rdata = enable_r;
      OFF_VECTOR: bus_rdata = vec_w;
      OFF_MASTER: bus_rdata = {30'd0, hw_en, master_en};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] status_r,
  input logic [31:0] enable_r,
  input logic [31:0] pending_w,
  input logic [31:0] hit,
  input logic [31:0] ack_mask,
  input logic        ack_wr,
  input logic        set_wr,
  input logic        clr_wr,
  input logic [31:0] bus_wdata,
  input logic        hw_en,
  input logic        irq_out,
  input logic [31:0] vec_w
);
  localparam logic [31:0] LMASK = irqc_pkg::line_mask(NUM_SRC);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != 0) |=> ((status_r & $past(hit)) == $past(hit)));

  assert_set_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((enable_r & $past(bus_wdata & LMASK)) == $past(bus_wdata & LMASK)));

  assert_clr_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((enable_r & $past(bus_wdata)) == 0));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((status_r & $past(ack_mask & ~hit)) == 0));

  assert_irq_has_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vec_w != 32'hFFFF_FFFF));

  assert_hw_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |=> hw_en);

  assert_vector_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_w != 32'hFFFF_FFFF) |-> pending_w[vec_w[4:0]]);

  assert_vector_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_w != 0) |-> (vec_w != 32'hFFFF_FFFF));
endmodule

bind mmio_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_r(status_r), .enable_r(enable_r),
  .pending_w(pending_w), .hit(hit), .ack_mask(ack_mask), .ack_wr(ack_wr),
  .set_wr(set_wr), .clr_wr(clr_wr), .bus_wdata(bus_wdata), .hw_en(hw_en),
  .irq_out(irq_out), .vec_w(vec_w)
);

// File: tb/mmio_irq_ctrl_test.sv
`timescale 1ns/100ps
module mmio_irq_ctrl_test;
  localparam int          N    = 8;
  localparam logic [31:0] EDGE = 32'h0000_00F0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [4:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int compared = 0;
  int mismatched = 0;

  // Behavioural reference state
  bit m_stat [32];
  bit m_en   [32];
  bit m_prev [32];
  bit m_me, m_hie;

  always #2.5 clk = ~clk;

  mmio_irq_ctrl #(.NUM_SRC(N), .EDGE_MASK(EDGE), .ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  function automatic logic [31:0] ref_read(input logic [4:0] a);
    logic [31:0] r;
    int word;
    r = 0;
    word = int'(a) / 4;
    if (word == 0) begin
      for (int i = 0; i < 32; i++) r[i] = m_stat[i];
    end else if (word == 1) begin
      for (int i = 0; i < 32; i++) r[i] = m_stat[i] && m_en[i];
    end else if (word == 2) begin
      for (int i = 0; i < 32; i++) r[i] = m_en[i];
    end else if (word == 6) begin
      r = 32'hFFFF_FFFF;
      for (int i = 0; i < 32; i++)
        if (m_stat[i] && m_en[i]) begin r = 32'(i); break; end
    end else if (word == 7) begin
      r = {30'd0, m_hie, m_me};
    end
    return r;
  endfunction

  function automatic bit ref_irq();
    bit any;
    any = 0;
    for (int i = 0; i < 32; i++) if (m_stat[i] && m_en[i]) any = 1;
    return m_me && m_hie && any;
  endfunction

  task automatic ref_clock(input logic [4:0] a, input bit w,
                           input logic [31:0] d, input logic [N-1:0] s);
    int word;
    bit hitv;
    word = int'(a) / 4;
    for (int i = 0; i < 32; i++) begin
      if (i >= N) begin
        m_stat[i] = 0; m_en[i] = 0;
        continue;
      end
      if (EDGE[i]) hitv = s[i] && !m_prev[i];
      else         hitv = s[i];
      if (w && word == 3 && d[i]) m_stat[i] = 0;
      if (hitv) m_stat[i] = 1;
      if (w && word == 2) m_en[i] = d[i];
      if (w && word == 4 && d[i]) m_en[i] = 1;
      if (w && word == 5 && d[i]) m_en[i] = 0;
      m_prev[i] = s[i];
    end
    if (w && word == 7) begin
      m_me = d[0];
      if (d[1]) m_hie = 1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (addr %h, time %0t)", tag, act, exp, addr, $time);
    end
  endtask

  // One bus cycle: drive, compare the combinational outputs, advance the model.
  task automatic step(input string tag, input logic [4:0] a, input bit w,
                      input logic [31:0] d, input logic [N-1:0] s);
    @(negedge clk);
    addr = a; we = w; wdata = d; src = s;
    #1;
    check(tag, rdata, ref_read(a));
    check({tag, " R6 irq"}, {31'd0, irq}, {31'd0, ref_irq()});
    @(posedge clk);
    ref_clock(a, w, d, s);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] lines;
    for (int i = 0; i < 32; i++) begin m_stat[i] = 0; m_en[i] = 0; m_prev[i] = 0; end
    m_me = 0; m_hie = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values on every offset
    for (int a = 0; a < 8; a++) step("R1 reset", 5'(a * 4), 0, 0, '0);

    // R7: master bits, permit is sticky
    step("R7 write 3", 5'h1C, 1, 32'h3, '0);
    step("R7 read", 5'h1C, 0, 0, '0);
    step("R7 write 0", 5'h1C, 1, 32'h0, '0);
    step("R7 sticky", 5'h1C, 0, 0, '0);
    step("R7 write 1", 5'h1C, 1, 32'h1, '0);

    // R3 and R9: enable write forms, upper bits stay zero
    step("R9 enable all", 5'h08, 1, 32'hFFFF_FFFF, '0);
    step("R9 read enable", 5'h08, 0, 0, '0);
    step("R3 replace", 5'h08, 1, 32'h0000_000F, '0);
    step("R3 set alias", 5'h10, 1, 32'h0000_0030, '0);
    step("R3 read", 5'h08, 0, 0, '0);
    step("R3 clear alias", 5'h14, 1, 32'h0000_0005, '0);
    step("R3 read", 5'h08, 0, 0, '0);

    // R2: level line 1 and edge line 5
    step("R2 level high", 5'h00, 0, 0, 8'h02);
    step("R2 level status", 5'h00, 0, 0, 8'h02);
    step("R2 edge rise", 5'h00, 0, 0, 8'h22);
    step("R2 edge held", 5'h00, 0, 0, 8'h22);
    step("R5 pending", 5'h04, 0, 0, 8'h20);
    step("R8 vector", 5'h18, 0, 0, 8'h00);

    // R4: acknowledge; level still high re-sets; edge gone clears
    step("R4 ack both", 5'h0C, 1, 32'h22, 8'h02);
    step("R4 status", 5'h00, 0, 0, 8'h00);
    step("R4 ack all", 5'h0C, 1, 32'hFFFF_FFFF, 8'h00);
    step("R4 status clear", 5'h00, 0, 0, 8'h00);
    step("R8 empty", 5'h18, 0, 0, 8'h00);
    step("R4 edge arrive", 5'h00, 0, 0, 8'h00);
    step("R4 ack with edge", 5'h0C, 1, 32'h20, 8'h20);
    step("R4 edge wins", 5'h00, 0, 0, 8'h20);

    // R10: ignored writes, write-only offsets read zero
    step("R10 wr status", 5'h00, 1, 32'h0, 8'h00);
    step("R10 wr pending", 5'h04, 1, 32'h0, 8'h00);
    step("R10 wr vector", 5'h18, 1, 32'h0, 8'h00);
    step("R10 read status", 5'h00, 0, 0, 8'h00);
    step("R10 read ack", 5'h0C, 0, 0, 8'h00);
    step("R10 read set", 5'h10, 0, 0, 8'h00);
    step("R10 read clear", 5'h14, 0, 0, 8'h00);

    // Mixed random traffic across all offsets (R2 R3 R4 R5 R6 R8)
    lines = '0;
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] d;
      logic [4:0]  a;
      bit          w;
      if ($urandom_range(0, 3) == 0) lines = N'($urandom);
      a = 5'($urandom_range(0, 7) * 4);
      w = ($urandom_range(0, 2) == 0);
      d = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
      if (a == 5'h1C && $urandom_range(0, 1) == 0) d[0] = 1'b1;
      step("R8 random", a, w, d, lines);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule